// File: doc/BRIEF.md
# Descriptor-Walking Bus-Master DMA Starter

This block is the control front end of one bus-master DMA channel. Software first writes a 32-bit command word: a table base address whose two low bits carry the transfer direction. It then writes a 16-bit count register. That second write is what launches the transfer. No separate go bit exists.

Once running, the block reads the table in memory one descriptor at a time. It issues one data burst per descriptor and steps an internal counter down once for every descriptor word it fetches. When the last entry is done, the counter has wrapped to all ones. The status register then settles on a fixed completion code that the host polls, and an interrupt line stays high until the next start. Any other value left at the end marks a failed or aborted transfer.

Memory traffic uses a plain request/grant handshake. A `mem_fetch` flag separates descriptor reads from data bursts. Drive timing and bus signalling sit outside the block.

Top module: `bmdma_start`

## Requirements
- R1: While reset is asserted and after it is released, `dma_sts` is 0x0000 and `dma_busy`, `dma_irq` and `mem_req` are low.
- R2: Bits [1:0] of the command word select the direction. Value 1 is memory-to-drive, and its data bursts have `mem_wr`=0. Value 2 is drive-to-memory, and its data bursts have `mem_wr`=1. The table base is the command word with bits [1:0] cleared.
- R3: The command register sits at `reg_addr` 0x04 and the count register at 0x06; with CHAN=1 both addresses have bit 7 set (0x84, 0x86). A count write starts a transfer only when the block is idle, `cfg_dma_en` and `cfg_bm_en` are both high, `chan_reset` is low and the direction is 1 or 2. Otherwise the write is dropped.
- R4: Entry k sits at table base + 8·k. Its first word is the burst address and its second word is the burst byte count. Both words are read with `mem_fetch`=1. Each entry then yields exactly one data burst with `mem_fetch`=0, `mem_addr` = entry address and `mem_len` = entry count. During the data phase, `mem_req` is raised only while `drq` is high.
- R5: An accepted count write loads the written value into `dma_sts`. The value drops by one on every granted descriptor-word fetch, so a transfer stalled in a data phase shows the loaded count minus the words fetched.
- R6: When the data burst of an entry is granted and the counter reads all ones (0xFFFF), the transfer ends. `dma_sts` becomes 0x00FF and `dma_busy` falls. While idle, `dma_sts` holds its value until a register write.
- R7: If the counter is already zero when an entry's first word is due, that word is not fetched. The transfer ends with `dma_sts` = 0xFF00. An even count therefore ends in error.
- R8: While busy, writes to the count register neither restart the transfer nor change `dma_sts`, and writes to the command register are discarded.
- R9: If `chan_reset` is high, or either enable is low, during a transfer, the block is idle on the next cycle with `dma_sts` = 0xFF00, and no grant in that cycle is taken.
- R10: A descriptor fetch request holds `mem_req` and `mem_addr` steady until `mem_gnt`, and every grant is consumed exactly once.
- R11: `dma_irq` is high exactly when the block is idle with `dma_sts` = 0x00FF. It rises only at the end of a transfer and drops on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register offset |
| reg_wdata | input | 32 | Host write data |
| cfg_dma_en | input | 1 | DMA enable from the channel configuration |
| cfg_bm_en | input | 1 | Bus-master enable from the channel configuration |
| chan_reset | input | 1 | Channel reset; aborts a running transfer |
| drq | input | 1 | Drive data request |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_rdata | input | 32 | Memory read data, valid with a fetch grant |
| mem_req | output | 1 | Memory request |
| mem_fetch | output | 1 | 1 = descriptor word read, 0 = data burst |
| mem_wr | output | 1 | Data burst writes memory (drive-to-memory) |
| mem_addr | output | 32 | Request address |
| mem_len | output | 32 | Byte count of the current data burst |
| dma_busy | output | 1 | Transfer in progress |
| dma_sts | output | 16 | Status/count value read by the host |
| dma_irq | output | 1 | Completion interrupt |

## Verification
Random tables of one to six entries in both directions are run with random grant and request gaps. Comparing each logged burst against its descriptor separates correct walking order, correct word pairing and correct direction from an off-by-one in the counter. Directed patterns stall a transfer in its data phase to read the partial count and to show that writes made while busy change nothing. Further directed patterns abort a transfer by channel reset and by each enable, which tells the error code apart from the completion code. Even and zero counts show that the premature wrap is caught before a stray fetch, and starts with a disabled enable, a bad direction or a wrong-channel address show that the launch gate holds.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FADDR = 2'd1,
    W_FCNT  = 2'd2,
    W_DATA  = 2'd3
  } walk_state_e;

  localparam logic [7:0] CMD_OFS  = 8'h04;
  localparam logic [7:0] CNT_OFS  = 8'h06;
  localparam logic [7:0] CHAN_SEL = 8'h80;
  localparam logic [1:0] DIR_TO_DRV = 2'd1;
  localparam logic [1:0] DIR_TO_MEM = 2'd2;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode #(
  parameter int CHAN  = 0,
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  input  logic             busy,
  output logic [W-1:0]     cmd_q,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] cnt_val
);
  import bmdma_pkg::*;

  localparam logic [7:0] SEL   = (CHAN != 0) ? CHAN_SEL : 8'h00;
  localparam logic [7:0] CMD_A = CMD_OFS | SEL;
  localparam logic [7:0] CNT_A = CNT_OFS | SEL;

  logic         cmd_en;
  logic [W-1:0] cmd_d;
  logic         unused_hi;

  always_comb begin
    cmd_en = reg_wr && (reg_addr == CMD_A) && !busy;
    cmd_d  = cmd_en ? reg_wdata : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign cnt_wr    = reg_wr && (reg_addr == CNT_A);
  assign cnt_val   = reg_wdata[CNT_W-1:0];
  assign unused_hi = ^reg_wdata[W-1:CNT_W];
endmodule

// File: rtl/bmdma_count.sv
module bmdma_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             set_ok,
  input  logic             set_err,
  output logic [CNT_W-1:0] sts_q,
  output logic             is_zero,
  output logic             is_ones
);
  localparam logic [CNT_W-1:0] DONE_CODE = {{(CNT_W-8){1'b0}}, 8'hFF};
  localparam logic [CNT_W-1:0] ERR_CODE  = {{(CNT_W-8){1'b1}}, 8'h00};

  logic [CNT_W-1:0] sts_d;

  always_comb begin
    sts_d = sts_q;
    if (set_err)     sts_d = ERR_CODE;
    else if (load)   sts_d = load_val;
    else if (set_ok) sts_d = DONE_CODE;
    else if (dec)    sts_d = sts_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign is_zero = (sts_q == '0);
  assign is_ones = &sts_q;
endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic [W-1:0] cmd_q,
  input  logic         cfg_dma_en,
  input  logic         cfg_bm_en,
  input  logic         chan_reset,
  input  logic         cnt_zero,
  input  logic         cnt_ones,
  input  logic         drq,
  input  logic         mem_gnt,
  input  logic [W-1:0] mem_rdata,
  output logic         busy,
  output logic         load,
  output logic         dec,
  output logic         set_ok,
  output logic         set_err,
  output logic         mem_req,
  output logic         mem_fetch,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_len
);
  import bmdma_pkg::*;

  localparam logic [W-1:0] STEP_WORD  = W'(4);
  localparam logic [W-1:0] STEP_ENTRY = W'(8);

  walk_state_e  st_q, st_d;
  logic [W-1:0] ptr_q, ptr_d;
  logic [W-1:0] ea_q, ea_d;
  logic [W-1:0] len_q, len_d;
  logic         wr_q, wr_d;
  logic         en_ok, dir_ok, abort;

  always_comb begin
    en_ok  = cfg_dma_en && cfg_bm_en;
    dir_ok = (cmd_q[1:0] == DIR_TO_DRV) || (cmd_q[1:0] == DIR_TO_MEM);
    busy   = (st_q != W_IDLE);
    abort  = busy && (chan_reset || !en_ok);

    st_d = st_q; ptr_d = ptr_q; ea_d = ea_q; len_d = len_q; wr_d = wr_q;
    load = 1'b0; dec = 1'b0; set_ok = 1'b0; set_err = 1'b0;
    mem_req = 1'b0; mem_fetch = 1'b0; mem_addr = ptr_q;

    case (st_q)
      W_IDLE: begin
        if (cnt_wr && en_ok && dir_ok && !chan_reset) begin
          load  = 1'b1;
          ptr_d = {cmd_q[W-1:2], 2'b00};
          wr_d  = (cmd_q[1:0] == DIR_TO_MEM);
          st_d  = W_FADDR;
        end
      end
      W_FADDR: begin
        mem_fetch = 1'b1;
        if (cnt_zero) begin
          set_err = 1'b1;
          st_d    = W_IDLE;
        end else begin
          mem_req = 1'b1;
          if (mem_gnt) begin
            ea_d = mem_rdata;
            dec  = 1'b1;
            st_d = W_FCNT;
          end
        end
      end
      W_FCNT: begin
        mem_fetch = 1'b1;
        mem_addr  = ptr_q + STEP_WORD;
        mem_req   = 1'b1;
        if (mem_gnt) begin
          len_d = mem_rdata;
          dec   = 1'b1;
          st_d  = W_DATA;
        end
      end
      default: begin
        mem_addr = ea_q;
        mem_req  = drq;
        if (drq && mem_gnt) begin
          if (cnt_ones) begin
            set_ok = 1'b1;
            st_d   = W_IDLE;
          end else begin
            ptr_d = ptr_q + STEP_ENTRY;
            st_d  = W_FADDR;
          end
        end
      end
    endcase

    if (abort) begin
      st_d = W_IDLE; set_err = 1'b1; set_ok = 1'b0; dec = 1'b0;
      load = 1'b0; mem_req = 1'b0; ptr_d = ptr_q; ea_d = ea_q; len_d = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      ptr_q <= '0;
      ea_q  <= '0;
      len_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      ea_q  <= ea_d;
      len_q <= len_d;
      wr_q  <= wr_d;
    end
  end

  assign mem_wr  = wr_q && (st_q == W_DATA);
  assign mem_len = len_q;
endmodule

// File: rtl/bmdma_start.sv
module bmdma_start #(
  parameter int CHAN  = 0,
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  input  logic             cfg_dma_en,
  input  logic             cfg_bm_en,
  input  logic             chan_reset,
  input  logic             drq,
  input  logic             mem_gnt,
  input  logic [W-1:0]     mem_rdata,
  output logic             mem_req,
  output logic             mem_fetch,
  output logic             mem_wr,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_len,
  output logic             dma_busy,
  output logic [CNT_W-1:0] dma_sts,
  output logic             dma_irq
);
  localparam logic [CNT_W-1:0] DONE_CODE = {{(CNT_W-8){1'b0}}, 8'hFF};

  logic [1:0]       rsync_q;
  logic             rst_i_n;
  logic [W-1:0]     cmd_q;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_val;
  logic             load, dec, set_ok, set_err, cnt_zero, cnt_ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  bmdma_decode #(.CHAN(CHAN), .W(W), .CNT_W(CNT_W)) u_decode (
    .clk(clk), .rst_n(rst_i_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(dma_busy), .cmd_q(cmd_q),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val)
  );

  bmdma_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .load(load), .load_val(cnt_val), .dec(dec),
    .set_ok(set_ok), .set_err(set_err), .sts_q(dma_sts),
    .is_zero(cnt_zero), .is_ones(cnt_ones)
  );

  bmdma_walker #(.W(W)) u_walker (
    .clk(clk), .rst_n(rst_i_n), .cnt_wr(cnt_wr), .cmd_q(cmd_q),
    .cfg_dma_en(cfg_dma_en), .cfg_bm_en(cfg_bm_en), .chan_reset(chan_reset),
    .cnt_zero(cnt_zero), .cnt_ones(cnt_ones), .drq(drq), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .busy(dma_busy), .load(load), .dec(dec),
    .set_ok(set_ok), .set_err(set_err), .mem_req(mem_req),
    .mem_fetch(mem_fetch), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_len(mem_len)
  );

  assign dma_irq = !dma_busy && (dma_sts == DONE_CODE);
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             cfg_dma_en,
  input logic             cfg_bm_en,
  input logic             chan_reset,
  input logic             mem_req,
  input logic             mem_fetch,
  input logic             mem_gnt,
  input logic [W-1:0]     mem_addr,
  input logic             dma_busy,
  input logic [CNT_W-1:0] dma_sts,
  input logic             dma_irq
);
  localparam logic [CNT_W-1:0] ERR_CODE = {{(CNT_W-8){1'b1}}, 8'h00};

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_busy |-> !mem_req);

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_fetch && !mem_gnt) |=>
      ((mem_req || chan_reset || !cfg_dma_en || !cfg_bm_en) && $stable(mem_addr)));

  // R9
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && chan_reset) |=> (!dma_busy && dma_sts == ERR_CODE));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_busy && !reg_wr) |=> $stable(dma_sts));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_irq) |-> $past(dma_busy));
endmodule

bind bmdma_start bmdma_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .cfg_dma_en(cfg_dma_en),
  .cfg_bm_en(cfg_bm_en), .chan_reset(chan_reset), .mem_req(mem_req),
  .mem_fetch(mem_fetch), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .dma_busy(dma_busy), .dma_sts(dma_sts), .dma_irq(dma_irq)
);

// File: tb/bmdma_start_bench.sv
`timescale 1ns/100ps
module bmdma_start_bench;
  logic        clk = 1'b0;
  logic        rst_n, reg_wr, cfg_dma_en, cfg_bm_en, chan_reset, drq, mem_gnt;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, mem_rdata, mem_addr, mem_len;
  logic        mem_req, mem_fetch, mem_wr, dma_busy, dma_irq;
  logic [15:0] dma_sts;

  bmdma_start u_bmdma_start (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cfg_dma_en(cfg_dma_en), .cfg_bm_en(cfg_bm_en),
    .chan_reset(chan_reset), .drq(drq), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_fetch(mem_fetch),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len),
    .dma_busy(dma_busy), .dma_sts(dma_sts), .dma_irq(dma_irq)
  );

  always #2.5 clk = ~clk;

  logic [31:0] dmem [0:255];
  assign mem_rdata = dmem[mem_addr[9:2]];

  int drq_mode = 1;
  always @(negedge clk) begin
    mem_gnt <= ($urandom % 4) != 0;
    drq     <= (drq_mode == 2) ? 1'b1 : (drq_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
  end

  logic [31:0] logA [0:511];
  logic [31:0] logL [0:511];
  logic        logW [0:511];
  int          log_n = 0;
  always @(posedge clk) begin
    if (mem_req && mem_gnt && !mem_fetch) begin
      logA[log_n % 512] <= mem_addr;
      logL[log_n % 512] <= mem_len;
      logW[log_n % 512] <= mem_wr;
      log_n <= log_n + 1;
    end
  end

  int n_chk = 0, n_fail = 0, base = 0, cur_e = 0, cur_dir = 1;
  logic [31:0] exA [0:7];
  logic [31:0] exL [0:7];
  logic [31:0] cur_tbl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && dma_busy; i++) @(negedge clk);
  endtask

  // builds a table in bench memory and writes the command word
  task automatic prep(input int e, input int dir);
    logic [31:0] r;
    int idx;
    r = $urandom; idx = ($urandom % 16) * 8;
    cur_tbl = {r[31:10], 10'(idx * 4)};
    cur_e = e; cur_dir = dir;
    for (int k = 0; k < e; k++) begin
      exA[k] = $urandom; exL[k] = $urandom;
      dmem[idx + 2*k] = exA[k]; dmem[idx + 2*k + 1] = exL[k];
    end
    hw(8'h04, cur_tbl | 32'(dir));
  endtask

  task automatic go(input int cnt);
    base = log_n;
    hw(8'h06, 32'(cnt));
  endtask

  task automatic verify_ok();
    chk(dma_sts == 16'h00FF, "R6 done status", 32'(dma_sts), 32'h00FF);
    chk(dma_irq == 1'b1 && !dma_busy, "R11 irq at end", 32'(dma_irq), 1);
    chk(log_n - base == cur_e, "R10 one burst per grant", 32'(log_n - base), 32'(cur_e));
    for (int k = 0; k < cur_e && k < log_n - base; k++) begin
      chk(logA[(base+k)%512] == exA[k] && logL[(base+k)%512] == exL[k],
          "R4 burst addr/len", logA[(base+k)%512], exA[k]);
      chk(logW[(base+k)%512] == (cur_dir == 2), "R2 direction", 32'(logW[(base+k)%512]), 32'(cur_dir == 2));
    end
  endtask

  task automatic run(input int e, input int dir);
    prep(e, dir);
    go(2*e - 1);
    chk(dma_sts == 16'(2*e - 1) && dma_busy, "R5 count loaded", 32'(dma_sts), 32'(2*e - 1));
    wait_idle();
    verify_ok();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=busy expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cfg_dma_en = 1'b1; cfg_bm_en = 1'b1; chan_reset = 1'b0;
    repeat (4) @(negedge clk);
    chk(dma_sts == 16'h0 && !dma_busy && !dma_irq && !mem_req, "R1 in reset", 32'(dma_sts), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dma_sts == 16'h0 && !dma_busy && !dma_irq && !mem_req, "R1 after reset", 32'(dma_sts), 0);

    run(1, 2);
    run(6, 1);
    for (int i = 0; i < 20; i++) run(1 + int'($urandom % 6), 1 + int'($urandom % 2));

    // R3 start gating
    cfg_dma_en = 1'b0; go(5); @(negedge clk);
    chk(!dma_busy && dma_sts == 16'h00FF, "R3 dma enable off", 32'(dma_sts), 32'h00FF);
    cfg_dma_en = 1'b1; cfg_bm_en = 1'b0; go(5); @(negedge clk);
    chk(!dma_busy && dma_sts == 16'h00FF, "R3 bus-master off", 32'(dma_sts), 32'h00FF);
    cfg_bm_en = 1'b1;
    hw(8'h04, cur_tbl | 32'd0); go(1); @(negedge clk);
    chk(!dma_busy && dma_sts == 16'h00FF, "R3 direction 0", 32'(dma_sts), 32'h00FF);
    hw(8'h04, cur_tbl | 32'd3); go(1); @(negedge clk);
    chk(!dma_busy && dma_sts == 16'h00FF, "R3 direction 3", 32'(dma_sts), 32'h00FF);
    prep(1, 1); hw(8'h86, 32'd1); @(negedge clk);
    chk(!dma_busy && dma_sts == 16'h00FF, "R3 other channel offset", 32'(dma_sts), 32'h00FF);

    // R8 writes while busy, R11 irq drop, R5 partial count
    drq_mode = 0;
    prep(3, 2); go(5);
    chk(!dma_irq, "R11 irq cleared by start", 32'(dma_irq), 0);
    repeat (30) @(negedge clk);
    chk(dma_sts == 16'd3 && dma_busy, "R5 stalled count", 32'(dma_sts), 3);
    hw(8'h06, 32'h0123);
    chk(dma_sts == 16'd3 && dma_busy, "R8 count write while busy", 32'(dma_sts), 3);
    hw(8'h04, 32'hFFFF_FFF1);
    drq_mode = 1; wait_idle(); verify_ok();
    go(5); wait_idle(); verify_ok(); // R8 command word kept

    // R9 aborts
    drq_mode = 0; prep(3, 1); go(5); repeat (20) @(negedge clk);
    chan_reset = 1'b1; @(negedge clk); chan_reset = 1'b0;
    chk(!dma_busy && dma_sts == 16'hFF00 && !dma_irq, "R9 channel reset abort", 32'(dma_sts), 32'hFF00);
    go(5); repeat (20) @(negedge clk);
    cfg_bm_en = 1'b0; @(negedge clk);
    chk(!dma_busy && dma_sts == 16'hFF00, "R9 bus-master drop abort", 32'(dma_sts), 32'hFF00);
    cfg_bm_en = 1'b1; go(5); repeat (20) @(negedge clk);
    cfg_dma_en = 1'b0; @(negedge clk);
    chk(!dma_busy && dma_sts == 16'hFF00, "R9 dma enable drop abort", 32'(dma_sts), 32'hFF00);
    cfg_dma_en = 1'b1; drq_mode = 1;

    // R7 even and zero counts
    prep(2, 1); go(2); wait_idle();
    chk(dma_sts == 16'hFF00 && !dma_irq, "R7 even count error", 32'(dma_sts), 32'hFF00);
    chk(log_n - base == 1 && logA[base%512] == exA[0], "R7 single burst before error", 32'(log_n - base), 1);
    go(0); wait_idle();
    chk(dma_sts == 16'hFF00 && log_n == base, "R7 zero count no burst", 32'(log_n - base), 0);

    run(2, 2);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule